// File: doc/BRIEF.md
# Pipelined Synchronous SRAM Core

This block is a single-clock synchronous static memory with a two-stage pipeline. On every rising edge it registers the address, three chip selects, the write controls and the write data. A registered write updates the array on the following edge without any handshake. A registered read loads the output register on the following edge, so read data are presented one full cycle after capture. The bus pins are split into an input path, an output path and a drive enable. A pad ring, or the parent level, turns these into a shared bidirectional data bus.

A write covers one or more byte lanes of nine bits each. A global write strobe writes every lane. Otherwise the per-lane enables are honoured only while a separate byte-write gate is asserted. A selected cycle with no lane enabled is a read. The asynchronous output enable gates the drive combinationally. The drive also stays off in any cycle whose registered operation is a write, which frees the bus for the master's write data. Deselect takes effect through the pipeline. A read captured just before a deselect cycle is still presented while that deselect is in the input register.

Top module: `sram_pipe_core`

## Requirements
- R1: All inputs except `oe_ni` are sampled on the rising edge of `clk_i`. Data for a read captured at edge k are on `data_o` with `data_oe_o` high after edge k+1, and they reflect every write captured at or before edge k-1.
- R2: A selected cycle with `gw_ni` low writes all lanes, whatever `bwe_ni` and `bw_ni` are.
- R3: With `gw_ni` high and `bwe_ni` low, each low bit `bw_ni[l]` writes data bits `[9*l+8 : 9*l]` and no others. Lane 0 is the least significant.
- R4: A selected cycle with no lane enabled is a read. This covers `gw_ni` high together with either `bwe_ni` high or all of `bw_ni` high. Such a cycle changes no stored data.
- R5: The device is selected only when `ce_ni`=0, `ce2_i`=1 and `ce2_ni`=0. A cycle captured otherwise performs no write and causes no drive.
- R6: When a read at edge k is followed by a deselect at edge k+1, the read data remain driven until edge k+2, and the bus is released after edge k+2.
- R7: While `oe_ni` is high, `data_oe_o` is low at once, without waiting for a clock edge.
- R8: `data_oe_o` is low in every cycle whose operation captured at the last edge is a write, even when the output register holds read data.
- R9: After reset the output register holds no read, and `data_oe_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address |
| ce_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Depth-expansion select, active high |
| ce2_ni | input | 1 | Depth-expansion select, active low |
| gw_ni | input | 1 | Global write of all lanes, active low |
| bwe_ni | input | 1 | Gate for the per-lane enables, active low |
| bw_ni | input | LANES | Per-lane write enables, active low |
| data_i | input | DATA_W | Write data from the bus |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| data_o | output | DATA_W | Read data toward the bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest situation to reach from the ports is a read sitting in the output register while the input register holds a write or a deselect. Those are the only moments where the write-quiet rule and the two-cycle deselect decide the bus drive. Constrained random traffic over a narrow address window produces back-to-back read/write/deselect mixes with frequent address reuse. Directed sequences also force read-then-write, read-then-deselect and mid-cycle output-enable toggles. Partial-lane writes are checked by read-back after the whole array has first been filled with known data.

// File: rtl/sram_pipe_pkg.sv
package sram_pipe_pkg;
  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/sram_in_reg.sv
module sram_in_reg
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce2_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [DATA_W-1:0] data_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  mask_o
);
  logic             sel;
  logic [LANES-1:0] mask_d;
  op_e              op_d;

  always_comb begin
    sel = !ce_ni && ce2_i && !ce2_ni;
    if (!gw_ni)       mask_d = '1;
    else if (!bwe_ni) mask_d = ~bw_ni;
    else              mask_d = '0;
    if (!sel) begin
      mask_d = '0;
      op_d   = OP_IDLE;
    end else if (mask_d != '0) begin
      op_d = OP_WRITE;
    end else begin
      op_d = OP_READ;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= OP_IDLE;
      addr_o <= '0;
      data_o <= '0;
      mask_o <= '0;
    end else begin
      op_o   <= op_d;
      addr_o <= addr_i;
      data_o <= data_i;
      mask_o <= mask_d;
    end
  end

  a_r2_global_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_ni && ce2_i && !ce2_ni && !gw_ni) |=> (mask_o == '1 && op_o == OP_WRITE));

  a_r3_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gw_ni && bwe_ni) |=> (mask_o == '0));

  a_r5_deselect_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ce_ni && ce2_i && !ce2_ni) |=> (op_o == OP_IDLE && mask_o == '0));
endmodule

// File: rtl/sram_bank.sv
module sram_bank
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  mask_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (mask_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (op_i == OP_READ) rd_q <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end
endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
  import sram_pipe_pkg::*;
#(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_s1_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= (op_s1_i == OP_READ);
  end

  // a registered write owns the bus for the master
  assign drive_o = vld_q && (op_s1_i != OP_WRITE) && !oe_ni;
  assign data_o  = drive_o ? rdata_i : '0;
endmodule

// File: rtl/sram_pipe_core.sv
module sram_pipe_core
  import sram_pipe_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  localparam int LANES = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              ce2_i,
  input  logic              ce2_ni,
  input  logic              gw_ni,
  input  logic              bwe_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  logic [LANES-1:0]  s1_mask;
  logic [DATA_W-1:0] rdata;

  sram_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in (
    .clk_i, .rst_ni, .addr_i, .ce_ni, .ce2_i, .ce2_ni, .gw_ni, .bwe_ni, .bw_ni, .data_i,
    .op_o(s1_op), .addr_o(s1_addr), .data_o(s1_data), .mask_o(s1_mask)
  );

  sram_bank #(.ADDR_W(ADDR_W), .LANES(LANES)) u_bank (
    .clk_i, .op_i(s1_op), .addr_i(s1_addr), .wdata_i(s1_data), .mask_i(s1_mask),
    .rdata_o(rdata)
  );

  sram_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i, .rst_ni, .op_s1_i(s1_op), .rdata_i(rdata), .oe_ni,
    .data_o, .drive_o(data_oe_o)
  );

  a_r1_drive_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(s1_op == OP_READ));

  a_r6_deselect_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(s1_op == OP_READ) && s1_op == OP_IDLE && !oe_ni) |-> data_oe_o);

  a_r7_oe_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  a_r8_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s1_op == OP_WRITE) |-> !data_oe_o);
endmodule

// File: tb/tb_sram_pipe_core.sv
module tb_sram_pipe_core;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 36;
  localparam int LANES  = 4;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              ce_n = 1'b1, ce2 = 1'b0, ce2_n = 1'b1;
  logic              gw_n = 1'b1, bwe_n = 1'b1;
  logic [LANES-1:0]  bw_n = '1;
  logic [DATA_W-1:0] din = '0;
  logic              oe_n = 1'b0;
  logic [DATA_W-1:0] data_o;
  logic              data_oe_o;

  int checks = 0;
  int errors = 0;

  logic [DATA_W-1:0] mdl [DEPTH];
  logic              m1_rd = 1'b0;
  logic [LANES-1:0]  m1_mask = '0;
  logic [ADDR_W-1:0] m1_a = '0;
  logic [DATA_W-1:0] m1_d = '0;
  logic              m2_v = 1'b0;
  logic [DATA_W-1:0] m2_d = '0;

  always #(CLK_P/2) clk = ~clk;

  sram_pipe_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .ce2_i(ce2), .ce2_ni(ce2_n),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .data_i(din), .oe_ni(oe_n),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic chk(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [LANES-1:0] lane_mask(input logic g, input logic b, input logic [LANES-1:0] bw);
    if (!g) return '1;
    if (!b) return ~bw;
    return '0;
  endfunction

  // one clock: update the model at the edge, then compare outputs
  task automatic tick(input string tag);
    logic sel;
    logic [LANES-1:0] mk;
    logic exp_oe;
    @(posedge clk);
    m2_v = m1_rd;
    m2_d = mdl[m1_a];
    for (int l = 0; l < LANES; l++)
      if (m1_mask[l]) mdl[m1_a][l*9 +: 9] = m1_d[l*9 +: 9];
    sel = !ce_n && ce2 && !ce2_n;
    mk  = sel ? lane_mask(gw_n, bwe_n, bw_n) : '0;
    m1_mask = mk;
    m1_rd   = sel && (mk == '0);
    m1_a    = addr;
    m1_d    = din;
    #(CLK_P/4);
    exp_oe = m2_v && (m1_mask == '0) && !oe_n;
    chk(tag, {35'd0, data_oe_o}, {35'd0, exp_oe});
    if (exp_oe) chk(tag, data_o, m2_d);
    @(negedge clk);
  endtask

  task automatic set_op(input logic c, input logic c2, input logic c2n, input logic g,
                        input logic b, input logic [LANES-1:0] bw,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ce_n = c; ce2 = c2; ce2_n = c2n; gw_n = g; bwe_n = b; bw_n = bw; addr = a; din = d;
  endtask

  task automatic wr_full(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input string tag);
    set_op(0, 1, 0, 0, 1, '1, a, d);
    tick(tag);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
    set_op(0, 1, 0, 1, 1, '1, a, '0);
    tick(tag);
  endtask

  task automatic idle(input string tag);
    set_op(1, 1, 0, 1, 1, '1, '0, '0);
    tick(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_P/4);
    chk("R9 reset no drive", {35'd0, data_oe_o}, 36'd0);
    @(negedge clk);
    idle("R9");
    idle("R9");

    // fill array with known data
    for (int a = 0; a < DEPTH; a++)
      wr_full(a[ADDR_W-1:0], {$urandom, $urandom} & {DATA_W{1'b1}}, "R1 fill");
    idle("R1");

    // R2: global write with all lane enables off
    set_op(0, 1, 0, 0, 1, '1, 8'd3, 36'h9_ABCD_1234);
    tick("R2");
    rd(8'd3, "R2");
    idle("R2");
    chk("R2 global write read-back", data_o, 36'h9_ABCD_1234);

    // R3: lane 2 only
    set_op(0, 1, 0, 1, 0, 4'b1011, 8'd3, 36'h0_5555_5555);
    tick("R3");
    rd(8'd3, "R3");
    idle("R3");
    chk("R3 lane2 merge", data_o, {9'h13A, 9'h155 ^ 9'h155 ^ 9'h155, 9'h04D, 9'h034} & 36'h0 | {9'h135, 9'h155, 9'h11A, 9'h034} & 36'h0 | mdl[3]);
    chk("R3 lane2 exact", data_o, {36'h9_ABCD_1234 & ~{9'h0, 9'h1FF, 18'h0}} | {9'h0, 9'h155, 18'h0} & {9'h0, 9'h1FF, 18'h0} | (36'h0_5555_5555 & {9'h0, 9'h1FF, 18'h0}) & 36'h0);

    // R4: gate off with lane enables low is a read, data unchanged
    set_op(0, 1, 0, 1, 1, 4'b0000, 8'd3, 36'hF_FFFF_FFFF);
    tick("R4");
    idle("R4");
    chk("R4 no-lane cycle reads", data_o, mdl[3]);
    set_op(0, 1, 0, 1, 0, 4'b1111, 8'd3, 36'hF_FFFF_FFFF);
    tick("R4");
    idle("R4");
    chk("R4 all lanes off reads", data_o, mdl[3]);

    // R5: each select missing blocks write and drive
    set_op(0, 0, 0, 0, 1, '1, 8'd3, 36'h0);
    tick("R5");
    set_op(1, 1, 0, 0, 1, '1, 8'd3, 36'h0);
    tick("R5");
    set_op(0, 1, 1, 1, 1, '1, 8'd3, 36'h0);
    tick("R5");
    chk("R5 deselected read no drive", {35'd0, data_oe_o}, 36'd0);
    rd(8'd3, "R5");
    idle("R5");
    chk("R5 data kept", data_o, mdl[3]);

    // R6: read then deselect
    rd(8'd9, "R6");
    idle("R6");
    chk("R6 tail still driven", {35'd0, data_oe_o}, 36'd1);
    chk("R6 tail data", data_o, mdl[9]);
    idle("R6");
    chk("R6 released", {35'd0, data_oe_o}, 36'd0);

    // R7: asynchronous output enable
    rd(8'd9, "R7");
    idle("R7");
    oe_n = 1'b1;
    #1;
    chk("R7 oe high blocks", {35'd0, data_oe_o}, 36'd0);
    oe_n = 1'b0;
    #1;
    chk("R7 oe low drives", {35'd0, data_oe_o}, 36'd1);
    @(negedge clk);

    // R8: read then write
    rd(8'd9, "R8");
    wr_full(8'd10, 36'h1_2345_6789, "R8");
    chk("R8 write quiet", {35'd0, data_oe_o}, 36'd0);
    idle("R8");

    // constrained random traffic over a narrow window
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      set_op(pick == 4'd0, pick != 4'd1, pick == 4'd2,
             ($urandom_range(0, 3) != 0), 1'($urandom), 4'($urandom),
             8'($urandom_range(0, 15)), {$urandom, $urandom} & {DATA_W{1'b1}});
      oe_n = ($urandom_range(0, 7) == 0);
      tick("R1 random");
    end
    oe_n = 1'b0;
    idle("R1");
    idle("R1");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule